// File: doc/BRIEF.md
# Triple-Redundant Self-Repairing Scan Register

This block stores a word of `WIDTH` bits three times over, in copies A, B and C. Each copy has its own clock, reset, data input, data output and scan chain. Every bit of every copy is an edge-triggered flip-flop built from two level-sensitive latches. The first latch is open while the clock is low and the second while the clock is high. The first latch has no vote, so the data-to-output path matches an ordinary flip-flop.

When the second latch of a bit closes (clock low), it stops holding only its own value. Its feedback becomes the majority of its own value and the matching bits of the other two copies. A copy that has been corrupted therefore repairs itself as soon as its clock drops. It keeps repairing itself for as long as its clock is held low. A per-copy scan enable replaces the vote with plain self-feedback, which lets each copy be tested on its own. In that mode each copy becomes a mux-D shift chain.

A per-copy, per-bit upset input inverts the value that a bit's second latch takes while that copy's clock is high. This lets a corrupted state be created on purpose.

Top module: `tmr_scan_reg`

## Requirements
- R1: An active-low reset of a copy clears that copy's outputs and scan output to 0 at once, without any clock edge.
- R2: In functional mode (scan enable low) with no upset, a copy's output takes its data input on each rising edge of that copy's clock. All three copies agree after the falling edge.
- R3: Each copy moves only on its own clock. If only copy A is clocked with new data, A shows the new data while its clock is high and B and C keep the old word. After A's falling edge the lone new value is voted back to the old word.
- R4: An upset asserted on bits of one copy during its high phase shows as those bits inverted at that copy's output. After the falling edge the copy holds the majority value again.
- R5: With two copies' clocks held low, repeated upsets in the third copy over several of its own clock pulses are each repaired in the low phase. The stored word never changes.
- R6: If the same bit is upset in two copies in the same high phase, all three copies, the untouched one included, hold the inverted bit after the falling edge.
- R7: With scan enable high, an upset in one copy stays in that copy through the low phase and is not voted out. When scan enable drops during a low phase, all copies settle to the bitwise majority.
- R8: With scan enable high, each rising edge moves bit i-1 into bit i and the scan input into bit 0, ignoring the data input. The scan output equals bit WIDTH-1 of the same copy.
- R9: An upset input asserted while the copy's clock stays low has no effect on the output.
- R10: A wrong data input on one copy is captured and shown by that copy while its clock is high, then replaced by the majority value after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of copy A |
| rst_n_a | input | 1 | Asynchronous active-low reset of copy A |
| scan_en_a | input | 1 | Scan mode of copy A (disables voting) |
| scan_in_a | input | 1 | Serial input of copy A's chain |
| d_a | input | WIDTH | Parallel data into copy A |
| upset_a | input | WIDTH | Per-bit upset into copy A |
| q_a | output | WIDTH | Stored word of copy A |
| scan_out_a | output | 1 | Bit WIDTH-1 of copy A |
| clk_b | input | 1 | Clock of copy B |
| rst_n_b | input | 1 | Asynchronous active-low reset of copy B |
| scan_en_b | input | 1 | Scan mode of copy B |
| scan_in_b | input | 1 | Serial input of copy B's chain |
| d_b | input | WIDTH | Parallel data into copy B |
| upset_b | input | WIDTH | Per-bit upset into copy B |
| q_b | output | WIDTH | Stored word of copy B |
| scan_out_b | output | 1 | Bit WIDTH-1 of copy B |
| clk_c | input | 1 | Clock of copy C |
| rst_n_c | input | 1 | Asynchronous active-low reset of copy C |
| scan_en_c | input | 1 | Scan mode of copy C |
| scan_in_c | input | 1 | Serial input of copy C's chain |
| d_c | input | WIDTH | Parallel data into copy C |
| upset_c | input | WIDTH | Per-bit upset into copy C |
| q_c | output | WIDTH | Stored word of copy C |
| scan_out_c | output | 1 | Bit WIDTH-1 of copy C |

## Verification
The bench samples each copy in the middle of the high phase and in the middle of the low phase. Checking both phases shows whether a fault is first visible and then repaired. A design that voted in the first latch would never show the fault, and one that never voted would keep it.

Three cases get most of the attention:
- A copy clocked alone with new data, which a design sharing one clock would let stick.
- Two copies upset on the same bit, where a design that skipped the peer vote would leave the third copy untouched.
- Scan mode, where a design that kept voting would erase a forced error before it reached the scan output.

Upsets asserted while the clock is gated low must leave the output alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // two-of-three vote of one bit
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/tmr_bit.sv
module tmr_bit
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic upset,
    input  logic d_i,
    input  logic peer_x,
    input  logic peer_y,
    output logic q_o
);

    logic mst_q;
    logic slv_q;

    // first latch: open in the low phase, no vote on the data path
    always_latch begin
        if (!rst_n)
            mst_q <= 1'b0;
        else if (!clk)
            mst_q <= d_i;
    end

    // second latch: open in the high phase; when closed, the feedback is either
    // the three-way vote (functional) or plain self-hold (scan)
    always_latch begin
        if (!rst_n)
            slv_q <= 1'b0;
        else if (clk)
            slv_q <= mst_q ^ upset;
        else if (!scan_en)
            slv_q <= maj3(slv_q, peer_x, peer_y);
    end

    assign q_o = slv_q;

    // reset holds the output at zero
    assert_reset_clears_R1: assert property (@(posedge clk) !rst_n |-> (q_o == 1'b0));

    // at the end of the low phase the first latch holds the applied data
    assert_master_tracks_d_R2: assert property (@(posedge clk) disable iff (!rst_n) mst_q == d_i);

endmodule

// File: rtl/tmr_copy.sv
module tmr_copy
    import tmr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] upset,
    input  logic [WIDTH-1:0] peer_x,
    input  logic [WIDTH-1:0] peer_y,
    output logic [WIDTH-1:0] q,
    output logic             scan_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] din_d;
    logic [WIDTH-1:0] vote_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // mux-D: the chain moves from bit 0 towards bit MSB
        if (i == 0) begin : g_head
            assign din_d[i] = scan_en ? scan_in : d[i];
        end else begin : g_link
            assign din_d[i] = scan_en ? q[i-1] : d[i];
        end

        assign vote_d[i] = maj3(q[i], peer_x[i], peer_y[i]);

        tmr_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .scan_en (scan_en),
            .upset   (upset[i]),
            .d_i     (din_d[i]),
            .peer_x  (peer_x[i]),
            .peer_y  (peer_y[i]),
            .q_o     (q[i])
        );
    end

    assign scan_out = q[MSB];

    // after a full low phase in functional mode the copy sits on the majority
    assert_vote_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> (q == vote_d));

    // in scan mode each cycle moves the word up by one bit
    assert_scan_shift_R8: assert property (@(negedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en) && (upset == '0)) |-> (q[MSB:1] == $past(q[MSB-1:0])));

endmodule

// File: rtl/tmr_scan_reg.sv
module tmr_scan_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_a,
    input  logic             rst_n_a,
    input  logic             scan_en_a,
    input  logic             scan_in_a,
    input  logic [WIDTH-1:0] d_a,
    input  logic [WIDTH-1:0] upset_a,
    output logic [WIDTH-1:0] q_a,
    output logic             scan_out_a,
    input  logic             clk_b,
    input  logic             rst_n_b,
    input  logic             scan_en_b,
    input  logic             scan_in_b,
    input  logic [WIDTH-1:0] d_b,
    input  logic [WIDTH-1:0] upset_b,
    output logic [WIDTH-1:0] q_b,
    output logic             scan_out_b,
    input  logic             clk_c,
    input  logic             rst_n_c,
    input  logic             scan_en_c,
    input  logic             scan_in_c,
    input  logic [WIDTH-1:0] d_c,
    input  logic [WIDTH-1:0] upset_c,
    output logic [WIDTH-1:0] q_c,
    output logic             scan_out_c
);

    // each copy votes with the two others
    tmr_copy #(.WIDTH(WIDTH)) u_copy_a (
        .clk(clk_a), .rst_n(rst_n_a), .scan_en(scan_en_a), .scan_in(scan_in_a),
        .d(d_a), .upset(upset_a), .peer_x(q_b), .peer_y(q_c),
        .q(q_a), .scan_out(scan_out_a)
    );

    tmr_copy #(.WIDTH(WIDTH)) u_copy_b (
        .clk(clk_b), .rst_n(rst_n_b), .scan_en(scan_en_b), .scan_in(scan_in_b),
        .d(d_b), .upset(upset_b), .peer_x(q_a), .peer_y(q_c),
        .q(q_b), .scan_out(scan_out_b)
    );

    tmr_copy #(.WIDTH(WIDTH)) u_copy_c (
        .clk(clk_c), .rst_n(rst_n_c), .scan_en(scan_en_c), .scan_in(scan_in_c),
        .d(d_c), .upset(upset_c), .peer_x(q_a), .peer_y(q_b),
        .q(q_c), .scan_out(scan_out_c)
    );

endmodule

// File: tb/tmr_scan_reg_bench.sv
module tmr_scan_reg_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
    logic clk_a, clk_b, clk_c;
    assign clk_a = clk & en_a;
    assign clk_b = clk & en_b;
    assign clk_c = clk & en_c;

    logic rst_n_a = 1'b0, rst_n_b = 1'b0, rst_n_c = 1'b0;
    logic se_a = 1'b0, se_b = 1'b0, se_c = 1'b0;
    logic si_a = 1'b0, si_b = 1'b0, si_c = 1'b0;
    logic [W-1:0] d_a = '0, d_b = '0, d_c = '0;
    logic [W-1:0] up_a = '0, up_b = '0, up_c = '0;
    logic [W-1:0] q_a, q_b, q_c;
    logic so_a, so_b, so_c;

    int checks = 0;
    int errors = 0;

    tmr_scan_reg #(.WIDTH(W)) u_tmr_scan_reg (
        .clk_a(clk_a), .rst_n_a(rst_n_a), .scan_en_a(se_a), .scan_in_a(si_a),
        .d_a(d_a), .upset_a(up_a), .q_a(q_a), .scan_out_a(so_a),
        .clk_b(clk_b), .rst_n_b(rst_n_b), .scan_en_b(se_b), .scan_in_b(si_b),
        .d_b(d_b), .upset_b(up_b), .q_b(q_b), .scan_out_b(so_b),
        .clk_c(clk_c), .rst_n_c(rst_n_c), .scan_en_c(se_c), .scan_in_c(si_c),
        .d_c(d_c), .upset_c(up_c), .q_c(q_c), .scan_out_c(so_c)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // sample points: middle of the high phase, middle of the low phase
    task automatic to_high(); @(posedge clk); #2; endtask
    task automatic to_low();  @(negedge clk); #2; endtask

    task automatic set_d(input logic [W-1:0] v); d_a = v; d_b = v; d_c = v; endtask
    task automatic set_en(input logic a, input logic b, input logic c); en_a = a; en_b = b; en_c = c; endtask

    task automatic t_reset();
        set_en(1, 1, 1);
        set_d(8'hFF);
        to_high();
        check("R1 reset q_a", q_a, '0);
        check("R1 reset q_c", q_c, '0);
        check("R1 reset scan_out", {5'b0, so_a, so_b, so_c}, '0);
        to_low();
        rst_n_a = 1'b1; rst_n_b = 1'b1; rst_n_c = 1'b1;
    endtask

    task automatic t_capture(input logic [W-1:0] p);
        set_en(1, 1, 1);
        set_d(p);
        to_high();
        check("R2 capture high q_a", q_a, p);
        to_low();
        check("R2 capture low q_b", q_b, p);
        check("R2 capture low q_c", q_c, p);
    endtask

    task automatic t_dfault(input logic [W-1:0] p);
        d_a = p ^ 8'h10;
        to_high();
        check("R10 wrong d visible q_a", q_a, p ^ 8'h10);
        check("R10 peer unaffected q_b", q_b, p);
        to_low();
        check("R10 wrong d voted out q_a", q_a, p);
        d_a = p;
    endtask

    task automatic t_seu(input logic [W-1:0] p);
        up_c = 8'h04;
        to_high();
        check("R4 upset visible q_c", q_c, p ^ 8'h04);
        to_low();
        check("R4 upset repaired q_c", q_c, p);
        check("R4 peer unchanged q_a", q_a, p);
        up_c = '0;
    endtask

    task automatic t_upset_low(input logic [W-1:0] p);
        set_en(0, 0, 0);
        up_b = 8'hFF;
        to_high();
        check("R9 upset in gated low ignored high", q_b, p);
        to_low();
        check("R9 upset in gated low ignored low", q_b, p);
        up_b = '0;
    endtask

    task automatic t_gated(input logic [W-1:0] p);
        set_en(1, 0, 0);
        up_a = 8'h81;
        for (int k = 0; k < 3; k++) begin
            to_high();
            check("R5 lone copy upset visible", q_a, p ^ 8'h81);
            to_low();
            check("R5 lone copy repaired", q_a, p);
        end
        up_a = '0;
        check("R5 gated copy kept word", q_b, p);
    endtask

    task automatic t_indep(input logic [W-1:0] p);
        set_en(1, 0, 0);
        d_a = 8'h5A;
        to_high();
        check("R3 clocked copy shows new", q_a, 8'h5A);
        check("R3 unclocked copy keeps old b", q_b, p);
        check("R3 unclocked copy keeps old c", q_c, p);
        to_low();
        check("R3 lone new value voted back", q_a, p);
        d_a = p;
        set_en(1, 1, 1);
    endtask

    task automatic t_double(input logic [W-1:0] p);
        up_a = 8'h02; up_b = 8'h02;
        to_high();
        check("R6 third copy follows data while high", q_c, p);
        to_low();
        check("R6 third copy follows faulty majority", q_c, p ^ 8'h02);
        check("R6 faulty copy keeps inversion", q_a, p ^ 8'h02);
        up_a = '0; up_b = '0;
        to_high();
        to_low();
        check("R2 next capture restores", q_c, p);
    endtask

    task automatic t_scan();
        logic [W-1:0] ea, eb, ec;
        logic [W-1:0] pat_b;
        pat_b = 8'hC5;
        rst_n_a = 1'b0; rst_n_b = 1'b0; rst_n_c = 1'b0;
        #1;
        check("R1 async reset without clock", q_b, '0);
        rst_n_a = 1'b1; rst_n_b = 1'b1; rst_n_c = 1'b1;
        ea = '0; eb = '0; ec = '0;
        se_a = 1'b1; se_b = 1'b1; se_c = 1'b1;
        set_d(8'hFF);
        set_en(1, 1, 1);
        for (int k = 0; k < W; k++) begin
            si_a = 1'b0;
            si_b = pat_b[W-1-k];
            si_c = 1'b0;
            up_a = (k == 0) ? 8'h01 : 8'h00;
            to_high();
            ea = {ea[W-2:0], si_a} ^ up_a;
            eb = {eb[W-2:0], si_b};
            ec = {ec[W-2:0], si_c};
            check("R8 shift q_a", q_a, ea);
            check("R8 shift q_b", q_b, eb);
            to_low();
            check("R7 scan fault kept q_a", q_a, ea);
            check("R8 shift q_c", q_c, ec);
            up_a = '0;
        end
        check("R8 fault reached scan_out_a", {7'b0, so_a}, 8'h01);
        check("R8 scan_out_b is top bit", {7'b0, so_b}, 8'h01);
        check("R8 scan_out_c", {7'b0, so_c}, 8'h00);
        check("R8 pattern loaded q_b", q_b, pat_b);
        // leave scan mode in the low phase: vote resumes
        se_a = 1'b0; se_b = 1'b0; se_c = 1'b0;
        #2;
        check("R7 vote resumes q_a", q_a, 8'h80);
        check("R7 vote resumes q_b", q_b, 8'h80);
        check("R7 vote resumes q_c", q_c, 8'h80);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        to_low();
        t_reset();
        t_capture(8'hA5);
        t_capture(8'h3C);
        t_dfault(8'h3C);
        t_seu(8'h3C);
        t_upset_low(8'h3C);
        t_gated(8'h3C);
        t_indep(8'h3C);
        t_double(8'h3C);
        t_scan();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule